// File: doc/BRIEF.md
# Dispatch Group Slot Allocator

This block builds one dispatch group per clock from an in-order window of up to five decoded instructions. Each candidate carries a 4-bit class code, and the internal-op count follows from that code. The allocator walks the window oldest first. It places each instruction into the next free slots of a five-slot group. The group closes at the first instruction that cannot legally be placed, and that instruction waits for the next cycle.

Slots 1 to 4 carry non-branch internal ops. Slot 5 is reserved for a branch. Each occupied slot is routed to an issue queue, chosen by class, and to one of the two paired units of that queue, chosen by slot position. The finished group is held in an output register with a valid/ready handshake. A consumed count tells the upstream buffer how far to advance.

Class codes: 0 integer, 1 load, 2 store, 3 floating-point, 4 branch, 5 condition-register (single-slot CR logical or single-field move), 6 cracked into 2 ops, 7 cracked into 3 ops, 8 cracked into 4 ops (needs slots 1 to 4). Codes 9 to 15 are treated as integer.

Top module: `dispatch_group_alloc`

## Requirements
- R1: While reset is asserted, and until the first group is loaded afterwards, `out_valid` is 0, `slot_vld` is all zero and `take_cnt` is 0.
- R2: Instructions fill slots 1 to 4 in program order, each starting at the first free slot. `take_cnt` equals the number of instructions placed. An unoccupied slot outputs class 0 and queue 0.
- R3: Non-branch ops never use more than slots 1 to 4. The first instruction that does not fit in the remaining slots closes the group, is not counted in `take_cnt`, and no younger instruction is placed after it.
- R4: A branch (code 4) is placed only in slot 5, whatever slots are already filled. Any unfilled slots among 1 to 4 stay empty, and the group closes after the branch.
- R5: A 2-op cracked instruction (code 6) takes two adjacent slots. A 3-op cracked instruction (code 7) takes three adjacent slots. Both report their own class code in every slot they occupy.
- R6: A 4-op cracked instruction (code 8) is placed only as the first instruction of a group, where it takes slots 1 to 4. Otherwise it closes the group.
- R7: A condition-register op (code 5) is placed only in slot 1. Otherwise it closes the group.
- R8: `slot_unit` is 0 (unit 1) for slots 1, 4 and 5, and 1 (unit 2) for slots 2 and 3. `slot_q` per occupied slot is 0 integer (codes 0, 6, 7, 8 and 9 to 15), 1 load/store, 2 floating-point, 3 branch/condition-register.
- R9: While `out_valid` is 1 and `out_ready` is 0, the group outputs hold steady, `in_ready` is 0 and `take_cnt` is 0.
- R10: Only the first `in_cnt` candidates are considered. Candidates at or beyond `in_cnt` are never placed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Candidate window is valid |
| in_ready | output | 1 | Allocator can accept a group this cycle |
| in_cnt | input | 3 | Number of valid candidates, 0 to 5 |
| in_cls | input | 20 | Candidate class codes, candidate k in bits [4k+3:4k], candidate 0 oldest |
| take_cnt | output | 3 | Instructions consumed this cycle |
| out_valid | output | 1 | Group register holds a group |
| out_ready | input | 1 | Downstream accepts the group |
| slot_vld | output | 5 | Per-slot occupied flag, bit i is slot i+1 |
| slot_cls | output | 20 | Per-slot class code, slot i+1 in bits [4i+3:4i] |
| slot_q | output | 10 | Per-slot issue queue, slot i+1 in bits [2i+1:2i] |
| slot_unit | output | 5 | Per-slot paired-unit select, 0 unit 1, 1 unit 2 |

## Verification
The bench builds the block with its defaults: five slots and 4-bit class codes. With these values every closing rule can be reached with hand-computed groups: a full four-op group that leaves a fifth integer behind, a branch that jumps to slot 5 over empty slots, a 2-op cracked instruction overflowing the fourth slot, and a condition-register op or 4-op crack arriving after slot 1. A truncated `in_cnt` and a stalled output register cover the handshake side.

// File: rtl/dga_pkg.sv
package dga_pkg;
  localparam int CLS_W = 4;
  localparam int Q_W   = 2;

  typedef enum logic [CLS_W-1:0] {
    C_INT   = 4'd0,
    C_LOAD  = 4'd1,
    C_STORE = 4'd2,
    C_FP    = 4'd3,
    C_BR    = 4'd4,
    C_CR    = 4'd5,
    C_K2    = 4'd6,
    C_K3    = 4'd7,
    C_K4    = 4'd8
  } cls_e;

  typedef enum logic [Q_W-1:0] {
    Q_INT = 2'd0,
    Q_LS  = 2'd1,
    Q_FP  = 2'd2,
    Q_BC  = 2'd3
  } queue_e;

  function automatic int op_count(input logic [CLS_W-1:0] c);
    case (c)
      C_K2:    return 2;
      C_K3:    return 3;
      C_K4:    return 4;
      default: return 1;
    endcase
  endfunction

  function automatic logic [Q_W-1:0] queue_of(input logic [CLS_W-1:0] c);
    case (c)
      C_LOAD, C_STORE: return Q_LS;
      C_FP:            return Q_FP;
      C_BR, C_CR:      return Q_BC;
      default:         return Q_INT;
    endcase
  endfunction
endpackage

// File: rtl/dga_alloc.sv
module dga_alloc
  import dga_pkg::*;
#(
  parameter int NUM_SLOTS = 5,
  localparam int CNT_W = $clog2(NUM_SLOTS + 1),
  localparam int BR_SLOT = NUM_SLOTS - 1
) (
  input  logic [CNT_W-1:0]           cand_cnt,
  input  logic [NUM_SLOTS*CLS_W-1:0] cand_cls,
  output logic [CNT_W-1:0]           granted,
  output logic [NUM_SLOTS-1:0]       g_vld,
  output logic [NUM_SLOTS*CLS_W-1:0] g_cls
);
  int pos;
  int need;
  int n;
  logic open;
  logic fits;
  logic [CLS_W-1:0] c;

  always_comb begin
    pos   = 0;
    need  = 0;
    n     = 0;
    open  = 1'b1;
    fits  = 1'b0;
    c     = '0;
    g_vld = '0;
    g_cls = '0;
    for (int k = 0; k < NUM_SLOTS; k++) begin
      c = cand_cls[k*CLS_W +: CLS_W];
      if (open && (k < int'(cand_cnt))) begin
        if (c == C_BR) begin
          g_vld[BR_SLOT] = 1'b1;
          g_cls[BR_SLOT*CLS_W +: CLS_W] = c;
          n    = n + 1;
          open = 1'b0;
        end else begin
          need = op_count(c);
          fits = (pos + need <= BR_SLOT) &&
                 (!((c == C_CR) || (c == C_K4)) || (pos == 0));
          if (fits) begin
            for (int j = 0; j < BR_SLOT; j++) begin
              if ((j >= pos) && (j < pos + need)) begin
                g_vld[j] = 1'b1;
                g_cls[j*CLS_W +: CLS_W] = c;
              end
            end
            pos = pos + need;
            n   = n + 1;
          end else begin
            open = 1'b0;
          end
        end
      end
    end
    granted = CNT_W'(n);
  end
endmodule

// File: rtl/dga_route.sv
module dga_route
  import dga_pkg::*;
#(
  parameter int NUM_SLOTS = 5,
  localparam int BR_SLOT = NUM_SLOTS - 1
) (
  input  logic [NUM_SLOTS-1:0]       r_vld,
  input  logic [NUM_SLOTS*CLS_W-1:0] r_cls,
  output logic [NUM_SLOTS*Q_W-1:0]   r_q,
  output logic [NUM_SLOTS-1:0]       r_unit
);
  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    localparam logic SECOND = (i != BR_SLOT) && (((i % 4) == 1) || ((i % 4) == 2));
    assign r_unit[i] = SECOND;
    assign r_q[i*Q_W +: Q_W] = r_vld[i] ? queue_of(r_cls[i*CLS_W +: CLS_W]) : '0;
  end
endmodule

// File: rtl/dga_group_reg.sv
module dga_group_reg
  import dga_pkg::*;
#(
  parameter int NUM_SLOTS = 5
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       load_en,
  input  logic                       drain,
  input  logic [NUM_SLOTS-1:0]       d_vld,
  input  logic [NUM_SLOTS*CLS_W-1:0] d_cls,
  output logic                       q_valid,
  output logic [NUM_SLOTS-1:0]       q_vld,
  output logic [NUM_SLOTS*CLS_W-1:0] q_cls
);
  logic                       valid_nxt;
  logic [NUM_SLOTS-1:0]       vld_nxt;
  logic [NUM_SLOTS*CLS_W-1:0] cls_nxt;

  always_comb begin
    valid_nxt = q_valid;
    vld_nxt   = q_vld;
    cls_nxt   = q_cls;
    if (load_en) begin
      valid_nxt = 1'b1;
      vld_nxt   = d_vld;
      cls_nxt   = d_cls;
    end else if (drain) begin
      valid_nxt = 1'b0;
      vld_nxt   = '0;
      cls_nxt   = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_valid <= 1'b0;
      q_vld   <= '0;
      q_cls   <= '0;
    end else begin
      q_valid <= valid_nxt;
      q_vld   <= vld_nxt;
      q_cls   <= cls_nxt;
    end
  end
endmodule

// File: rtl/dispatch_group_alloc.sv
module dispatch_group_alloc
  import dga_pkg::*;
#(
  parameter int NUM_SLOTS = 5,
  localparam int CNT_W = $clog2(NUM_SLOTS + 1),
  localparam int CW = 4,
  localparam int QW = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [CNT_W-1:0]        in_cnt,
  input  logic [NUM_SLOTS*CW-1:0] in_cls,
  output logic [CNT_W-1:0]        take_cnt,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [NUM_SLOTS-1:0]    slot_vld,
  output logic [NUM_SLOTS*CW-1:0] slot_cls,
  output logic [NUM_SLOTS*QW-1:0] slot_q,
  output logic [NUM_SLOTS-1:0]    slot_unit
);
  logic [1:0] rst_sync;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  logic [CNT_W-1:0]           granted;
  logic [NUM_SLOTS-1:0]       g_vld;
  logic [NUM_SLOTS*CLS_W-1:0] g_cls;
  logic                       accept;

  dga_alloc #(.NUM_SLOTS(NUM_SLOTS)) u_alloc (
    .cand_cnt (in_cnt),
    .cand_cls (in_cls),
    .granted  (granted),
    .g_vld    (g_vld),
    .g_cls    (g_cls)
  );

  assign in_ready = rst_int_n && (!out_valid || out_ready);
  assign accept   = in_valid && in_ready && (granted != '0);
  assign take_cnt = accept ? granted : '0;

  dga_group_reg #(.NUM_SLOTS(NUM_SLOTS)) u_greg (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .load_en (accept),
    .drain   (out_ready),
    .d_vld   (g_vld),
    .d_cls   (g_cls),
    .q_valid (out_valid),
    .q_vld   (slot_vld),
    .q_cls   (slot_cls)
  );

  dga_route #(.NUM_SLOTS(NUM_SLOTS)) u_route (
    .r_vld  (slot_vld),
    .r_cls  (slot_cls),
    .r_q    (slot_q),
    .r_unit (slot_unit)
  );
endmodule

// File: rtl/dispatch_group_alloc_chk.sv
module dispatch_group_alloc_chk #(
  parameter int NUM_SLOTS = 5,
  localparam int CNT_W = $clog2(NUM_SLOTS + 1)
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   in_ready,
  input logic [CNT_W-1:0]       in_cnt,
  input logic [CNT_W-1:0]       take_cnt,
  input logic                   out_valid,
  input logic                   out_ready,
  input logic [NUM_SLOTS-1:0]   slot_vld,
  input logic [NUM_SLOTS*4-1:0] slot_cls
);
  localparam int BR = NUM_SLOTS - 1;

  // R9
  hold_on_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(slot_vld) && $stable(slot_cls)));

  // R9
  no_take_when_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> (take_cnt == '0));

  // R10
  take_within_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_cnt <= in_cnt);

  // R4
  last_slot_branch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slot_vld[BR] |-> (slot_cls[BR*4 +: 4] == 4'd4));

  // R1
  idle_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (slot_vld == '0));

  for (genvar i = 0; i < BR; i++) begin : g_s
    // R4
    no_early_branch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      slot_vld[i] |-> (slot_cls[i*4 +: 4] != 4'd4));
    if (i > 0) begin : g_tail
      // R7
      cr_first_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slot_vld[i] |-> (slot_cls[i*4 +: 4] != 4'd5));
      // R2
      packed_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slot_vld[i] |-> slot_vld[i-1]);
    end
  end
endmodule

bind dispatch_group_alloc dispatch_group_alloc_chk #(.NUM_SLOTS(NUM_SLOTS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_ready  (in_ready),
  .in_cnt    (in_cnt),
  .take_cnt  (take_cnt),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .slot_vld  (slot_vld),
  .slot_cls  (slot_cls)
);

// File: tb/dispatch_group_alloc_test.sv
`timescale 1ns/1ps
module dispatch_group_alloc_test;
  localparam logic [3:0] INT = 4'd0, LD = 4'd1, ST = 4'd2, FP = 4'd3, BR = 4'd4,
                         CR = 4'd5, K2 = 4'd6, K3 = 4'd7, K4 = 4'd8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_ready, out_valid, out_ready;
  logic [2:0]  in_cnt, take_cnt;
  logic [19:0] in_cls, slot_cls;
  logic [4:0]  slot_vld, slot_unit;
  logic [9:0]  slot_q;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  dispatch_group_alloc uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_cnt(in_cnt), .in_cls(in_cls), .take_cnt(take_cnt),
    .out_valid(out_valid), .out_ready(out_ready), .slot_vld(slot_vld),
    .slot_cls(slot_cls), .slot_q(slot_q), .slot_unit(slot_unit)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [19:0] w5(input logic [3:0] a, b, c, d, e);
    return {e, d, c, b, a};
  endfunction

  function automatic logic [9:0] q5(input logic [1:0] a, b, c, d, e);
    return {e, d, c, b, a};
  endfunction

  // drive a window, check take_cnt before the edge and the group after it
  task automatic group(input string req, input logic [19:0] cls, input logic [2:0] cnt,
                       input logic [2:0] exp_take, input logic [4:0] exp_vld,
                       input logic [19:0] exp_cls, input logic [9:0] exp_q);
    @(negedge clk);
    in_valid = 1'b1; in_cnt = cnt; in_cls = cls;
    #1;
    chk({req, " take"}, 32'(take_cnt), 32'(exp_take));
    @(posedge clk); #1;
    chk({req, " vld"}, 32'(slot_vld), 32'(exp_vld));
    chk({req, " cls"}, 32'(slot_cls), 32'(exp_cls));
    chk({req, " q"}, 32'(slot_q), 32'(exp_q));
    @(negedge clk);
    in_valid = 1'b0;
    @(posedge clk); #1;
  endtask

  task automatic t_reset;
    chk("R1 out_valid", 32'(out_valid), 0);
    chk("R1 slot_vld", 32'(slot_vld), 0);
    chk("R1 take", 32'(take_cnt), 0);
  endtask

  task automatic t_full_int;
    group("R3 five int", w5(INT, INT, INT, INT, INT), 3'd5, 3'd4, 5'b01111,
          w5(INT, INT, INT, INT, 0), q5(0, 0, 0, 0, 0));
    chk("R8 unit", 32'(slot_unit), 32'(5'b00110));
  endtask

  task automatic t_branch;
    group("R4 ld fp br", w5(LD, FP, BR, INT, INT), 3'd5, 3'd3, 5'b10011,
          w5(LD, FP, 0, 0, BR), q5(1, 2, 0, 0, 3));
    group("R4 br first", w5(BR, INT, INT, INT, INT), 3'd5, 3'd1, 5'b10000,
          w5(0, 0, 0, 0, BR), q5(0, 0, 0, 0, 3));
    group("R4 st int br", w5(ST, INT, BR, 0, 0), 3'd3, 3'd3, 5'b10011,
          w5(ST, INT, 0, 0, BR), q5(1, 0, 0, 0, 3));
  endtask

  task automatic t_cr;
    group("R7 int cr", w5(INT, CR, INT, 0, 0), 3'd3, 3'd1, 5'b00001,
          w5(INT, 0, 0, 0, 0), q5(0, 0, 0, 0, 0));
    group("R7 cr int", w5(CR, INT, 0, 0, 0), 3'd2, 3'd2, 5'b00011,
          w5(CR, INT, 0, 0, 0), q5(3, 0, 0, 0, 0));
  endtask

  task automatic t_cracked;
    group("R5 int k2 k2", w5(INT, K2, K2, 0, 0), 3'd3, 3'd2, 5'b00111,
          w5(INT, K2, K2, 0, 0), q5(0, 0, 0, 0, 0));
    group("R5 k3 fp", w5(K3, FP, INT, 0, 0), 3'd3, 3'd2, 5'b01111,
          w5(K3, K3, K3, FP, 0), q5(0, 0, 0, 2, 0));
  endtask

  task automatic t_k4;
    group("R6 int k4", w5(INT, K4, 0, 0, 0), 3'd2, 3'd1, 5'b00001,
          w5(INT, 0, 0, 0, 0), q5(0, 0, 0, 0, 0));
    group("R6 k4 br", w5(K4, BR, 0, 0, 0), 3'd2, 3'd2, 5'b11111,
          w5(K4, K4, K4, K4, BR), q5(0, 0, 0, 0, 3));
  endtask

  task automatic t_cnt;
    group("R10 cnt2", w5(INT, LD, FP, INT, 0), 3'd2, 3'd2, 5'b00011,
          w5(INT, LD, 0, 0, 0), q5(0, 1, 0, 0, 0));
    group("R2 mixed", w5(FP, ST, LD, INT, INT), 3'd5, 3'd4, 5'b01111,
          w5(FP, ST, LD, INT, 0), q5(2, 1, 1, 0, 0));
  endtask

  task automatic t_stall;
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1; in_cnt = 3'd1; in_cls = w5(FP, 0, 0, 0, 0);
    #1 chk("R9 first take", 32'(take_cnt), 1);
    @(posedge clk); #1;
    @(negedge clk);
    in_cnt = 3'd2; in_cls = w5(LD, ST, 0, 0, 0);
    #1;
    chk("R9 in_ready", 32'(in_ready), 0);
    chk("R9 take zero", 32'(take_cnt), 0);
    @(posedge clk); #1;
    chk("R9 held vld", 32'(slot_vld), 32'(5'b00001));
    chk("R9 held cls", 32'(slot_cls), 32'(w5(FP, 0, 0, 0, 0)));
    @(negedge clk);
    out_ready = 1'b1;
    #1 chk("R9 release take", 32'(take_cnt), 2);
    @(posedge clk); #1;
    chk("R9 next cls", 32'(slot_cls), 32'(w5(LD, ST, 0, 0, 0)));
    @(negedge clk);
    in_valid = 1'b0;
    @(posedge clk); #1;
    chk("R9 drained", 32'(out_valid), 0);
  endtask

  initial begin
    #40000;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_cnt = '0; in_cls = '0; out_ready = 1'b1;
    repeat (3) @(posedge clk);
    #1 t_reset();
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1 t_reset();
    t_full_int();
    t_branch();
    t_cr();
    t_cracked();
    t_k4();
    t_cnt();
    t_stall();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule